// File: doc/BRIEF.md
# Composite Sample Gain and Offset Stage

This block sits on the path of 8-bit composite video samples before they reach the scaler, the data slicer and the output port. Each sample is taken relative to mid-scale (128), multiplied by an 8-bit gain in which 64 means unity, rounded, and then shifted by an 8-bit offset. The result is limited to the codes 1 through 254, so that 0 and 255 stay free for timing references downstream.

The gain and offset arrive as plain control pins. They are captured together with the sample when that sample is accepted, so every output is computed from one consistent pair of settings. With gain 64 and offset 128 (the values the controlling registers reset to), the stage passes every sample through unchanged except for the clamp. For such a source, sync bottom stays at 1, black with setup at 71, the black shoulder at 60, and white at 209 (199 without setup).

Samples move through a two-stage pipeline: multiply and round, then add and clamp. Both ends use a valid/ready handshake. A transfer happens on a rising edge where valid and ready are both high. The pipeline advances as one unit: `in_ready` is high whenever the output register is empty or the consumer is ready. While the consumer holds `out_ready` low with a sample on the output, the output sample and all staged samples hold still.

Top module: `cvbs_gain_offset`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: Each output equals clamp(floor((gain*(x-128) + 32) / 64) + offset), using the gain and offset present on the pins in the cycle that sample x was accepted.
- R3: The product is rounded half-up before the divide by 64. For example, gain 32 with x=129 gives offset+1, and gain 32 with x=127 gives offset+0.
- R4: A result below 1 is output as 1; `out_data` is never 0 while `out_valid` is high.
- R5: A result above 254 is output as 254; `out_data` is never 255 while `out_valid` is high.
- R6: With gain 64 and offset 128, an input in 1..254 is output unchanged (for example 1, 60, 71, 199 and 209).
- R7: With `out_ready` held high, a sample accepted in one cycle appears on the output two cycles later.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` keep their values on the next cycle. `in_ready` equals `!out_valid || out_ready`. No sample is lost or duplicated.
- R9: Changing gain or offset after a sample is accepted does not change that sample's result.
- R10: Gain 255 with inputs 0 or 255 and any offset does not overflow; the result follows R2 and is clamped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage can accept a sample |
| in_data | input | 8 | Raw composite sample |
| cfg_gain | input | 8 | Gain, 64 = unity |
| cfg_offset | input | 8 | Offset added after scaling, 128 = mid-scale |
| out_valid | output | 1 | Adjusted sample present |
| out_ready | input | 1 | Consumer accepts the sample |
| out_data | output | 8 | Adjusted sample, 1..254 |

## Verification
On every cycle, the assertions check the limits of the output range, that the output holds while the consumer is stalled, the ready rule, the two-cycle timing when nothing stalls, and the empty state after reset. The exact arithmetic can only be shown by the bench's scenarios. These cover rounding at the half point, unity settings on the documented video levels, gain 255 at both input extremes, and settings that change every cycle. In all of them, each result is compared against a model that uses the settings present when that sample was accepted.

// File: rtl/cvbs_go_pkg.sv
package cvbs_go_pkg;
  localparam int SAMPLE_W = 8;
  localparam int GAIN_W   = 8;
  localparam int FRAC_W   = 6;
  localparam int MID      = 1 << (SAMPLE_W - 1);
  localparam int PROD_W   = SAMPLE_W + GAIN_W + 2;
  localparam int SUM_W    = PROD_W - FRAC_W + 1;
  localparam int CODE_MIN = 1;
  localparam int CODE_MAX = (1 << SAMPLE_W) - 2;

  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SUM_W-1:0]  sum_t;

  typedef struct packed {
    logic                signed_valid;
    sum_t                scaled;
    logic [SAMPLE_W-1:0] offset;
  } stage1_t;
endpackage

// File: rtl/cvbs_go_mul.sv
module cvbs_go_mul
  import cvbs_go_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [GAIN_W-1:0]   gain,
  input  logic [SAMPLE_W-1:0] offset,
  output stage1_t             s1
);
  localparam int HALF = 1 << (FRAC_W - 1);

  prod_t centred;
  prod_t product;
  prod_t rounded;

  always_comb begin
    centred = prod_t'({1'b0, in_data}) - prod_t'(MID);
    product = centred * prod_t'({1'b0, gain});
    rounded = (product + prod_t'(HALF)) >>> FRAC_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1.signed_valid <= 1'b0;
      s1.scaled       <= '0;
      s1.offset       <= SAMPLE_W'(MID);
    end else if (advance) begin
      s1.signed_valid <= in_valid;
      if (in_valid) begin
        s1.scaled <= rounded[SUM_W-1:0];
        s1.offset <= offset;
      end
    end
  end
endmodule

// File: rtl/cvbs_go_clamp.sv
module cvbs_go_clamp
  import cvbs_go_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  stage1_t             s1,
  output logic                s2_valid,
  output logic [SAMPLE_W-1:0] s2_data
);
  sum_t total;
  logic [SAMPLE_W-1:0] limited;

  always_comb begin
    total = s1.scaled + sum_t'({1'b0, s1.offset});
    if (total < sum_t'(CODE_MIN))      limited = SAMPLE_W'(CODE_MIN);
    else if (total > sum_t'(CODE_MAX)) limited = SAMPLE_W'(CODE_MAX);
    else                               limited = total[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_data  <= '0;
    end else if (advance) begin
      s2_valid <= s1.signed_valid;
      if (s1.signed_valid) s2_data <= limited;
    end
  end
endmodule

// File: rtl/cvbs_gain_offset.sv
module cvbs_gain_offset
  import cvbs_go_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [GAIN_W-1:0]   cfg_gain,
  input  logic [SAMPLE_W-1:0] cfg_offset,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data
);
  stage1_t s1;
  logic    advance;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  cvbs_go_mul u_mul (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .in_valid (in_valid),
    .in_data  (in_data),
    .gain     (cfg_gain),
    .offset   (cfg_offset),
    .s1       (s1)
  );

  cvbs_go_clamp u_clamp (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .s1       (s1),
    .s2_valid (out_valid),
    .s2_data  (out_data)
  );
endmodule

// File: rtl/cvbs_gain_offset_chk.sv
module cvbs_gain_offset_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       s1_valid
);
  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> !out_valid && in_ready);

  assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data != 8'd0);

  assert_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data != 8'd255);

  assert_two_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && (!out_valid || out_ready)) |=> out_valid);

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  assert_hold_data_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  assert_ready_rule_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind cvbs_gain_offset cvbs_gain_offset_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .s1_valid  (s1.signed_valid)
);

// File: tb/cvbs_gain_offset_tb.sv
module cvbs_gain_offset_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_data, cfg_gain, cfg_offset, out_data;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit done = 0;

  int    q_exp[$];
  int    q_cyc[$];
  string q_tag[$];
  bit    lat_check;
  bit    stall_seen;
  logic [7:0] stall_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvbs_gain_offset u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_gain(cfg_gain), .cfg_offset(cfg_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int model(int x, int g, int o);
    int p, r, t;
    p = g * (x - 128) + 32;
    r = (p >= 0) ? (p / 64) : -((-p + 63) / 64);
    t = r + o;
    if (t < 1) t = 1;
    if (t > 254) t = 254;
    return t;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at negedge, then observe the handshakes that the next edge will take.
  task automatic step(bit v, int x, int g, int o, bit rdy, string tag);
    @(negedge clk);
    in_valid = v; in_data = 8'(x); cfg_gain = 8'(g); cfg_offset = 8'(o); out_ready = rdy;
    #1;
    cycle++;
    check(in_ready == (!out_valid || out_ready), "R8 ready rule", int'(in_ready),
          int'(!out_valid || out_ready));
    if (stall_seen) begin
      check(out_valid && out_data == stall_data, "R8 hold under stall",
            int'(out_data), int'(stall_data));
    end
    stall_seen = out_valid && !out_ready;
    stall_data = out_data;
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R8 unexpected output", int'(out_data), -1);
      end else begin
        int e, c;
        string t;
        e = q_exp.pop_front(); c = q_cyc.pop_front(); t = q_tag.pop_front();
        check(int'(out_data) == e, t, int'(out_data), e);
        if (lat_check) check(cycle - c == 2, "R7 latency", cycle - c, 2);
      end
    end
    if (in_valid && in_ready) begin
      q_exp.push_back(model(x, g, o));
      q_cyc.push_back(cycle);
      q_tag.push_back(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    int lv[8];
    seed = 1234;
    void'($urandom(seed));
    rst = 1; in_valid = 0; in_data = 0; cfg_gain = 64; cfg_offset = 128; out_ready = 0;
    stall_seen = 0; lat_check = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

    lv = '{1, 60, 71, 199, 209, 128, 2, 253};
    foreach (lv[i]) step(1, lv[i], 64, 128, 1, "R6 unity level");
    step(1, 0, 64, 128, 1, "R4 clamp zero");
    step(1, 255, 64, 128, 1, "R5 clamp full");
    step(1, 129, 32, 100, 1, "R3 round half up");
    step(1, 127, 32, 100, 1, "R3 round half negative");
    step(1, 130, 1, 50, 1, "R3 small gain");
    step(1, 0, 255, 255, 1, "R10 gain max low");
    step(1, 255, 255, 255, 1, "R10 gain max high");
    step(1, 0, 255, 0, 1, "R10 gain max floor");
    step(1, 255, 255, 0, 1, "R10 gain max mid");
    step(1, 10, 200, 10, 1, "R4 negative floor");
    step(1, 240, 200, 250, 1, "R5 positive ceiling");
    for (int i = 0; i < 300; i++)
      step(1, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255), 1,
           "R9 settings per sample");
    step(0, 0, 64, 128, 1, "idle");
    step(0, 0, 64, 128, 1, "idle");
    step(0, 0, 64, 128, 1, "idle");

    lat_check = 0;
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 255), ($urandom_range(0, 2) != 0), "R2 random stall");
    for (int i = 0; i < 10; i++) step(0, 0, 64, 128, 1, "drain");
    check(q_exp.size() == 0, "R8 no lost sample", q_exp.size(), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule